// File: doc/BRIEF.md
# Multi-channel ADC command sequencer over SPI

This block is the SPI master for an eight-channel serial ADC. A host presents a 16-bit command and pulses `start`. The block first shifts the command out in one frame. It then counts the selected channels at run time and runs that many conversion frames, one per selected channel. Each frame is framed by an active-low sync strobe. Each frame returns one result word to the host, tagged with the index of the channel it belongs to.

A command with its write flag set replaces the stored channel selection. A command with the flag clear reuses the selection stored before. Because the frame count is taken from the mask while the block runs, one instance serves any subset of channels, from none to all eight. The serial clock comes from the system clock through a divider, and consecutive frames are kept apart by a guaranteed idle interval on the sync line.

Top module: `adc_cmd_sequencer`

## Requirements
- R1: The first frame of every accepted command carries a word built from the command. Bit 15 is the copied write flag. Bit 14 is always 0. Bits 13..6 are the 8-bit channel mask, with bit 6 selecting channel 0. Bits 5..0 are 0. The word is shifted MSB first.
- R2: While `spi_sync_n` is high, `spi_sclk` stays low. Every frame has exactly 16 rising edges of `spi_sclk`. `spi_mosi` changes only after falling edges, and `spi_miso` is captured on rising edges.
- R3: An accepted command produces exactly 1 + N frames, where N is the number of 1 bits in the effective mask.
- R4: When the write flag is 1, bits 13..6 of the command become the stored mask. When it is 0, those bits are ignored and the stored mask is used, unchanged.
- R5: Each result frame raises `res_valid` for exactly one cycle. `res_data` holds the 16 bits received in that frame, first bit as MSB. `res_chan` holds a 3-bit channel index, and results come in strictly ascending channel order.
- R6: With an empty effective mask, only the command frame is sent, `done` pulses, and no result is produced.
- R7: Between two frames, `spi_sync_n` stays high for at least two `spi_sclk` periods (4*HALF_DIV system clocks).
- R8: `busy` rises the cycle after `start` is accepted. `busy` falls in the same cycle as the one-cycle `done` pulse, and that pulse coincides with the last `res_valid`. A `start` that arrives while `busy` is high is ignored.
- R9: While `rst_n` is low at a clock edge, the block returns to idle with `spi_sync_n` high, `spi_sclk` low, `busy` low, and the stored mask cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Accept `cmd` when idle |
| cmd | input | 16 | Command: write flag, repeat bit, channel mask, spare bits |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the ADC |
| spi_miso | input | 1 | Serial data from the ADC |
| spi_sync_n | output | 1 | Active-low frame strobe |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 16 | Received result word |
| res_chan | output | 3 | Channel index of the result |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The block is driven with several kinds of mask:
- An empty mask shows whether the command-only path behaves differently from the result path.
- Single-bit masks at channel 0 and channel 7 test the ends of the channel walk.
- The full mask and sparse alternating masks show whether the frame count follows the population count rather than the position of the highest bit.
- Random commands, including a random repeat bit, check that the outgoing command word masks bits correctly.
- Write-flag-clear commands with unrelated mask bits, a stray `start` during a run, and a reset in mid-run show whether the stored mask is kept or cleared exactly when required.

// File: rtl/adc_seq_pkg.sv
// Package: shared state encodings for the ADC command sequencer.
// Assumes: nothing; pure type definitions.
package adc_seq_pkg;

    // Sequencer control states.
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CMD_ISSUE,
        SQ_CMD_WAIT,
        SQ_RES_ISSUE,
        SQ_RES_WAIT
    } seq_state_e;

    // Serial frame engine states.
    typedef enum logic [1:0] {
        EN_IDLE,
        EN_SHIFT,
        EN_GAP
    } eng_state_e;

endpackage

// File: rtl/chan_picker.sv
// chan_picker: counts the set bits of a channel mask and finds the lowest set bit.
// Assumes: purely combinational; the index output is 0 when the mask is empty.
module chan_picker #(
    parameter int N_CH  = 8,
    parameter int CH_W  = $clog2(N_CH),
    parameter int CNT_W = $clog2(N_CH + 1)
) (
    input  logic [N_CH-1:0]  mask,
    output logic [CNT_W-1:0] ones,
    output logic [CH_W-1:0]  low_idx,
    output logic             any
);

    // Population count and lowest-index scan in one pass.
    always_comb begin
        ones    = '0;
        low_idx = '0;
        any     = 1'b0;
        for (int i = 0; i < N_CH; i++) begin
            if (mask[i]) begin
                ones = ones + CNT_W'(1);
                if (!any) begin
                    low_idx = CH_W'(i);
                    any     = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cmd_formatter.sv
// cmd_formatter: builds the outgoing command word and selects the effective mask.
// Assumes: the write flag is the top bit, the repeat bit sits below it, and the
// mask sits directly under the repeat bit; all other bits are sent as zero.
module cmd_formatter #(
    parameter int FRAME_BITS = 16,
    parameter int N_CH       = 8
) (
    input  logic [FRAME_BITS-1:0] cmd,
    input  logic [N_CH-1:0]       saved_mask,
    output logic [FRAME_BITS-1:0] tx_word,
    output logic [N_CH-1:0]       eff_mask,
    output logic                  wr_flag
);

    localparam int WR_BIT   = FRAME_BITS - 1;
    localparam int RPT_BIT  = FRAME_BITS - 2;
    localparam int MASK_LSB = FRAME_BITS - 2 - N_CH;

    logic unused_cmd_bits;
    assign unused_cmd_bits = ^{cmd[RPT_BIT], cmd[MASK_LSB-1:0]};

    // Command word: write flag kept, repeat forced low, spare bits zeroed.
    always_comb begin
        tx_word                     = '0;
        tx_word[WR_BIT]             = cmd[WR_BIT];
        tx_word[MASK_LSB +: N_CH]   = cmd[MASK_LSB +: N_CH];
    end

    // Effective mask: new mask on write, otherwise the stored one.
    always_comb begin
        wr_flag  = cmd[WR_BIT];
        eff_mask = wr_flag ? cmd[MASK_LSB +: N_CH] : saved_mask;
    end

endmodule

// File: rtl/spi_frame_engine.sv
// spi_frame_engine: shifts one fixed-length frame out and in under a low sync strobe,
// then holds sync high for a guard interval before reporting ready again.
// Assumes: go is a one-cycle pulse given only while ready is high; clock idles low,
// output data changes after falling edges, input data is captured on rising edges.
module spi_frame_engine #(
    parameter int FRAME_BITS = 16,
    parameter int HALF_DIV   = 2,
    parameter int GAP_SCLK   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go,
    input  logic [FRAME_BITS-1:0] tx_word,
    output logic                  ready,
    output logic                  frame_done,
    output logic [FRAME_BITS-1:0] rx_word,
    output logic                  sclk,
    output logic                  mosi,
    input  logic                  miso,
    output logic                  sync_n
);
    import adc_seq_pkg::*;

    localparam int DIV_W    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int BIT_W    = $clog2(FRAME_BITS);
    localparam int GAP_CLKS = 2 * GAP_SCLK * HALF_DIV;
    localparam int GAP_W    = $clog2(GAP_CLKS + 1);

    eng_state_e            st;
    logic [DIV_W-1:0]      div_cnt;
    logic [BIT_W-1:0]      bit_cnt;
    logic [GAP_W-1:0]      gap_cnt;
    logic [FRAME_BITS-1:0] tx_sh;
    logic [FRAME_BITS-1:0] rx_sh;
    logic                  half_tick;

    assign half_tick  = (div_cnt == DIV_W'(HALF_DIV - 1));
    assign ready      = (st == EN_IDLE);
    assign rx_word    = rx_sh;
    assign mosi       = sync_n ? 1'b0 : tx_sh[FRAME_BITS-1];

    // Frame state machine, clock divider, shifters and guard interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= EN_IDLE;
            div_cnt    <= '0;
            bit_cnt    <= '0;
            gap_cnt    <= '0;
            tx_sh      <= '0;
            rx_sh      <= '0;
            sclk       <= 1'b0;
            sync_n     <= 1'b1;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            case (st)
                EN_IDLE: begin
                    if (go) begin
                        st      <= EN_SHIFT;
                        sync_n  <= 1'b0;
                        tx_sh   <= tx_word;
                        div_cnt <= '0;
                        bit_cnt <= '0;
                        sclk    <= 1'b0;
                    end
                end
                EN_SHIFT: begin
                    if (half_tick) begin
                        div_cnt <= '0;
                        if (!sclk) begin
                            sclk  <= 1'b1;
                            rx_sh <= {rx_sh[FRAME_BITS-2:0], miso};
                        end else begin
                            sclk  <= 1'b0;
                            tx_sh <= {tx_sh[FRAME_BITS-2:0], 1'b0};
                            if (bit_cnt == BIT_W'(FRAME_BITS - 1)) begin
                                st         <= EN_GAP;
                                sync_n     <= 1'b1;
                                frame_done <= 1'b1;
                                gap_cnt    <= '0;
                            end else begin
                                bit_cnt <= bit_cnt + BIT_W'(1);
                            end
                        end
                    end else begin
                        div_cnt <= div_cnt + DIV_W'(1);
                    end
                end
                EN_GAP: begin
                    if (gap_cnt == GAP_W'(GAP_CLKS - 1)) begin
                        st <= EN_IDLE;
                    end else begin
                        gap_cnt <= gap_cnt + GAP_W'(1);
                    end
                end
                default: st <= EN_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/adc_cmd_sequencer.sv
// adc_cmd_sequencer: accepts a command, sends it in one frame, then runs one
// result frame per selected channel in ascending channel order.
// Assumes: the ADC answers each frame with a full word; no repeat mode.
module adc_cmd_sequencer #(
    parameter int FRAME_BITS = 16,
    parameter int N_CH       = 8,
    parameter int HALF_DIV   = 2,
    parameter int GAP_SCLK   = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [FRAME_BITS-1:0]   cmd,
    output logic                    spi_sclk,
    output logic                    spi_mosi,
    input  logic                    spi_miso,
    output logic                    spi_sync_n,
    output logic                    res_valid,
    output logic [FRAME_BITS-1:0]   res_data,
    output logic [$clog2(N_CH)-1:0] res_chan,
    output logic                    busy,
    output logic                    done
);
    import adc_seq_pkg::*;

    localparam int CH_W  = $clog2(N_CH);
    localparam int CNT_W = $clog2(N_CH + 1);

    seq_state_e            state;
    logic [N_CH-1:0]       saved_mask;
    logic [N_CH-1:0]       remain_mask;
    logic [CNT_W-1:0]      frames_left;
    logic [FRAME_BITS-1:0] cmd_word_q;
    logic [FRAME_BITS-1:0] frame_tx;
    logic                  go_q;

    logic [FRAME_BITS-1:0] fmt_word;
    logic [N_CH-1:0]       eff_mask;
    logic                  wr_flag;
    logic [CNT_W-1:0]      eff_ones;
    logic [CH_W-1:0]       next_chan;
    logic                  eng_ready;
    logic                  eng_done;
    logic [FRAME_BITS-1:0] eng_rx;

    logic [CH_W-1:0]       unused_low_a;
    logic                  unused_any_a;
    logic [CNT_W-1:0]      unused_ones_b;
    logic                  unused_any_b;

    cmd_formatter #(.FRAME_BITS(FRAME_BITS), .N_CH(N_CH)) u_fmt (
        .cmd        (cmd),
        .saved_mask (saved_mask),
        .tx_word    (fmt_word),
        .eff_mask   (eff_mask),
        .wr_flag    (wr_flag)
    );

    chan_picker #(.N_CH(N_CH), .CH_W(CH_W), .CNT_W(CNT_W)) u_count (
        .mask    (eff_mask),
        .ones    (eff_ones),
        .low_idx (unused_low_a),
        .any     (unused_any_a)
    );

    chan_picker #(.N_CH(N_CH), .CH_W(CH_W), .CNT_W(CNT_W)) u_walk (
        .mask    (remain_mask),
        .ones    (unused_ones_b),
        .low_idx (next_chan),
        .any     (unused_any_b)
    );

    spi_frame_engine #(.FRAME_BITS(FRAME_BITS), .HALF_DIV(HALF_DIV), .GAP_SCLK(GAP_SCLK)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go_q),
        .tx_word    (frame_tx),
        .ready      (eng_ready),
        .frame_done (eng_done),
        .rx_word    (eng_rx),
        .sclk       (spi_sclk),
        .mosi       (spi_mosi),
        .miso       (spi_miso),
        .sync_n     (spi_sync_n)
    );

    assign busy = (state != SQ_IDLE);

    // Command acceptance, frame scheduling and result delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= SQ_IDLE;
            saved_mask  <= '0;
            remain_mask <= '0;
            frames_left <= '0;
            cmd_word_q  <= '0;
            frame_tx    <= '0;
            go_q        <= 1'b0;
            res_valid   <= 1'b0;
            res_data    <= '0;
            res_chan    <= '0;
            done        <= 1'b0;
        end else begin
            go_q      <= 1'b0;
            res_valid <= 1'b0;
            done      <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        cmd_word_q  <= fmt_word;
                        remain_mask <= eff_mask;
                        frames_left <= eff_ones;
                        if (wr_flag) saved_mask <= eff_mask;
                        state <= SQ_CMD_ISSUE;
                    end
                end
                SQ_CMD_ISSUE: begin
                    if (eng_ready) begin
                        frame_tx <= cmd_word_q;
                        go_q     <= 1'b1;
                        state    <= SQ_CMD_WAIT;
                    end
                end
                SQ_CMD_WAIT: begin
                    if (eng_done) begin
                        if (frames_left == '0) begin
                            done  <= 1'b1;
                            state <= SQ_IDLE;
                        end else begin
                            state <= SQ_RES_ISSUE;
                        end
                    end
                end
                SQ_RES_ISSUE: begin
                    if (eng_ready) begin
                        frame_tx <= '0;
                        go_q     <= 1'b1;
                        state    <= SQ_RES_WAIT;
                    end
                end
                SQ_RES_WAIT: begin
                    if (eng_done) begin
                        res_valid              <= 1'b1;
                        res_data               <= eng_rx;
                        res_chan               <= next_chan;
                        remain_mask[next_chan] <= 1'b0;
                        frames_left            <= frames_left - CNT_W'(1);
                        if (frames_left == CNT_W'(1)) begin
                            done  <= 1'b1;
                            state <= SQ_IDLE;
                        end else begin
                            state <= SQ_RES_ISSUE;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/adc_seq_checker.sv
// adc_seq_checker: protocol and ordering properties for adc_cmd_sequencer.
// Assumes: attached by bind; observes ports and the remaining-channel state.
module adc_seq_checker #(
    parameter int N_CH     = 8,
    parameter int CH_W     = 3,
    parameter int CNT_W    = 4,
    parameter int HALF_DIV = 2,
    parameter int GAP_SCLK = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             res_valid,
    input logic [CH_W-1:0]  res_chan,
    input logic             spi_sclk,
    input logic             spi_sync_n,
    input logic [N_CH-1:0]  remain_mask,
    input logic [CNT_W-1:0] frames_left
);
    localparam int GAP_CLKS = 2 * GAP_SCLK * HALF_DIV;
    localparam int HI_W     = $clog2(GAP_CLKS + 2) + 1;

    logic [HI_W-1:0] hi_cnt;
    logic            armed;
    logic [CH_W-1:0] last_chan;
    logic            seen_res;

    // Track how long sync has been high and whether any frame has run yet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
            armed  <= 1'b0;
        end else begin
            if (!spi_sync_n) begin
                hi_cnt <= '0;
                armed  <= 1'b1;
            end else if (hi_cnt != {HI_W{1'b1}}) begin
                hi_cnt <= hi_cnt + HI_W'(1);
            end
        end
    end

    // Remember the previous result channel within one command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_chan <= '0;
            seen_res  <= 1'b0;
        end else if (done) begin
            seen_res <= 1'b0;
        end else if (res_valid) begin
            last_chan <= res_chan;
            seen_res  <= 1'b1;
        end
    end

    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sync_n |-> !spi_sclk);

    p_count_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(remain_mask) == int'(frames_left)));

    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    p_chan_ascend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && seen_res) |-> (res_chan > last_chan));

    p_sync_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(spi_sync_n) && armed) |-> (int'(hi_cnt) >= GAP_CLKS));

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_busy_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_reset_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (spi_sync_n && !spi_sclk && !busy));

endmodule

bind adc_cmd_sequencer adc_seq_checker #(
    .N_CH     (N_CH),
    .CH_W     (CH_W),
    .CNT_W    (CNT_W),
    .HALF_DIV (HALF_DIV),
    .GAP_SCLK (GAP_SCLK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .res_valid   (res_valid),
    .res_chan    (res_chan),
    .spi_sclk    (spi_sclk),
    .spi_sync_n  (spi_sync_n),
    .remain_mask (remain_mask),
    .frames_left (frames_left)
);

// File: tb/sim_adc_cmd_sequencer.sv
`timescale 1ns/1ps
module sim_adc_cmd_sequencer;

    localparam int HALF_DIV = 2;
    localparam int GAP_MIN  = 4 * HALF_DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] cmd = '0;
    logic        spi_sclk, spi_mosi, spi_sync_n;
    logic        spi_miso = 1'b0;
    logic        res_valid, busy, done;
    logic [15:0] res_data;
    logic [2:0]  res_chan;

    always #2.5 clk = ~clk;

    adc_cmd_sequencer #(.HALF_DIV(HALF_DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_sync_n(spi_sync_n), .res_valid(res_valid), .res_data(res_data),
        .res_chan(res_chan), .busy(busy), .done(done)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ADC model: a new word per frame, MSB first, advanced on falling clock edges.
    int          g_frame = 0;
    logic [15:0] slave_cur = '0;
    logic [15:0] slave_sh = '0;
    always @(negedge spi_sync_n) begin
        g_frame++;
        slave_cur = 16'hC3A5 ^ 16'(g_frame * 16'h0F1D);
        slave_sh  = slave_cur;
        spi_miso  = slave_sh[15];
    end
    always @(negedge spi_sclk) begin
        if (!spi_sync_n) begin
            slave_sh = {slave_sh[14:0], 1'b0};
            spi_miso = slave_sh[15];
        end
    end

    // Monitor state, cleared per command.
    int          nfr, res_cnt, done_cnt, pulse_bad, sclk_bad, min_gap, hi_run, rise_cnt;
    bit          done_with_valid;
    logic [15:0] mosi_sh;
    logic [15:0] frm_mosi [16];
    int          frm_rise [16];
    logic [15:0] frm_word [16];
    logic [2:0]  r_ch [16];
    logic [15:0] r_dat [16];
    logic        p_sync = 1'b1, p_sclk = 1'b0, p_valid = 1'b0;

    task automatic clear_mon();
        nfr = 0; res_cnt = 0; done_cnt = 0; pulse_bad = 0; sclk_bad = 0;
        min_gap = 1000; hi_run = 0; rise_cnt = 0; done_with_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (spi_sync_n && spi_sclk) sclk_bad++;
        if (p_sync && !spi_sync_n) begin
            if (nfr > 0 && hi_run < min_gap) min_gap = hi_run;
            mosi_sh = '0; rise_cnt = 0;
        end
        if (!spi_sync_n && !p_sclk && spi_sclk) begin
            mosi_sh = {mosi_sh[14:0], spi_mosi};
            rise_cnt++;
        end
        if (!p_sync && spi_sync_n && nfr < 16) begin
            frm_mosi[nfr] = mosi_sh; frm_rise[nfr] = rise_cnt; frm_word[nfr] = slave_cur;
            nfr++;
        end
        hi_run = spi_sync_n ? hi_run + 1 : 0;
        if (res_valid) begin
            if (p_valid) pulse_bad++;
            if (res_cnt < 16) begin r_ch[res_cnt] = res_chan; r_dat[res_cnt] = res_data; end
            res_cnt++;
        end
        if (done) begin done_cnt++; done_with_valid = res_valid; end
        p_sync = spi_sync_n; p_sclk = spi_sclk; p_valid = res_valid;
    end

    function automatic int popc(input logic [7:0] m);
        int c = 0;
        for (int i = 0; i < 8; i++) c += int'(m[i]);
        return c;
    endfunction

    function automatic int nth_chan(input logic [7:0] m, input int n);
        int k = 0;
        for (int i = 0; i < 8; i++) begin
            if (m[i]) begin
                if (k == n) return i;
                k++;
            end
        end
        return -1;
    endfunction

    logic [7:0] model_mask = '0;

    task automatic run_cmd(input logic [15:0] c, input bit stray);
        logic [7:0]  eff;
        logic [15:0] exp_word;
        int          pc, waited;
        eff = c[15] ? c[13:6] : model_mask;
        if (c[15]) model_mask = c[13:6];
        pc = popc(eff);
        exp_word = {c[15], 1'b0, c[13:6], 6'b0};
        @(posedge clk); #1;
        clear_mon();
        start = 1'b1; cmd = c;
        @(posedge clk); #1;
        start = 1'b0;
        @(negedge clk);
        chk(busy === 1'b1, "R8", "busy after start", int'(busy), 1);
        if (stray) begin
            repeat (40) @(posedge clk);
            #1; start = 1'b1; cmd = 16'hFFFF;
            @(posedge clk); #1; start = 1'b0; cmd = c;
        end
        waited = 0;
        while (done_cnt == 0 && waited < 6000) begin
            @(posedge clk); waited++;
        end
        chk(done_cnt == 1, "R8", "done pulse count", done_cnt, 1);
        @(negedge clk);
        chk(busy === 1'b0, "R8", "busy after done", int'(busy), 0);
        repeat (3) @(negedge clk);
        chk(nfr == 1 + pc, "R3", "frame count", nfr, 1 + pc);
        chk(frm_mosi[0] === exp_word, "R1", "command word", int'(frm_mosi[0]), int'(exp_word));
        for (int f = 0; f < nfr; f++)
            chk(frm_rise[f] == 16, "R2", "rising edges in frame", frm_rise[f], 16);
        chk(sclk_bad == 0, "R2", "sclk high while sync high", sclk_bad, 0);
        chk(res_cnt == pc, "R5", "result count", res_cnt, pc);
        for (int i = 0; i < pc && i < res_cnt; i++) begin
            chk(int'(r_ch[i]) == nth_chan(eff, i), "R5", "result channel", int'(r_ch[i]), nth_chan(eff, i));
            chk(r_dat[i] === frm_word[i + 1], "R5", "result data", int'(r_dat[i]), int'(frm_word[i + 1]));
        end
        chk(pulse_bad == 0, "R5", "valid wider than one cycle", pulse_bad, 0);
        if (pc == 0) chk(res_cnt == 0 && nfr == 1, "R6", "empty mask results", res_cnt, 0);
        else chk(done_with_valid, "R8", "done with last result", int'(done_with_valid), 1);
        if (nfr > 1) chk(min_gap >= GAP_MIN, "R7", "sync high gap", min_gap, GAP_MIN);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] rc;
        void'($urandom(32'd20240607));
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(spi_sync_n === 1'b1, "R9", "sync in reset", int'(spi_sync_n), 1);
        chk(spi_sclk === 1'b0, "R9", "sclk in reset", int'(spi_sclk), 0);
        chk(busy === 1'b0 && done === 1'b0 && res_valid === 1'b0, "R9", "outputs in reset", int'(busy), 0);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        run_cmd(16'h3FC0, 1'b0);              // R9: WR=0 after reset, cleared mask
        run_cmd(16'h8000, 1'b0);              // R6: empty mask written
        run_cmd(16'h8040, 1'b0);              // channel 0 only
        run_cmd(16'h6000 | 16'h8000, 1'b0);   // channel 7 only, repeat bit set in input
        run_cmd(16'hBFFF, 1'b0);              // all channels
        run_cmd(16'h8000 | (16'hA5 << 6), 1'b0);
        run_cmd(16'h8000 | (16'h3C << 6), 1'b1); // R8: stray start ignored
        run_cmd(16'h0000, 1'b0);              // R4: reuse stored mask
        run_cmd(16'h3FFF & ~(16'h3C << 6), 1'b0); // R4: WR=0 mask bits ignored
        for (int k = 0; k < 16; k++) begin
            rc = 16'($urandom);
            run_cmd(rc, 1'b0);
        end
        // R9: reset in the middle of a command clears the stored mask.
        @(posedge clk); #1; start = 1'b1; cmd = 16'hBFC0;
        @(posedge clk); #1; start = 1'b0;
        repeat (100) @(posedge clk);
        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(spi_sync_n === 1'b1 && spi_sclk === 1'b0, "R9", "spi idle after reset", int'(spi_sync_n), 1);
        chk(busy === 1'b0, "R9", "busy after reset", int'(busy), 0);
        #1 rst_n = 1'b1;
        model_mask = '0;
        repeat (12) @(posedge clk);
        run_cmd(16'h0000, 1'b0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule